// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and a 512K x 8 asynchronous static RAM. The RAM has active-low chip select, output enable and write strobe. The host raises a single-beat request carrying a write flag, a 19-bit address and a data byte. The controller then runs one complete memory cycle. It ends the cycle with a one-clock completion pulse and, for a read, a captured data byte.

Writes are controlled by the write strobe. Chip select and the write strobe fall together, and output enable stays high throughout. The write strobe rises first. The data bus stays driven, and chip select stays low, for a hold interval after that rising edge; the interval is stretched when needed so the whole cycle meets the minimum cycle time.

Reads lower chip select and output enable together. The read waits out the longest of three intervals: address access, output-enable access and cycle time. The data is captured on the edge where that count expires.

Every interval is given in nanoseconds and converted to clock cycles by rounding up, with a floor of one cycle. New requests are taken only while the block is idle.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, chip select, output enable and write strobe are all high (inactive), the data bus is not driven, the completion pulse is low and the block reports ready.
- R2: During a write, output enable stays high throughout, and the write strobe is low for exactly WE_CYC consecutive clocks. WE_CYC is the larger of the rounded-up strobe width and the rounded-up data setup time.
- R3: During a write, the data bus is driven with the request's byte for the whole time the write strobe is low and through the hold interval, with no change while driven. It is released in the same clock that chip select returns high.
- R4: The memory address equals the request's address and does not change while chip select is low.
- R5: A read lowers chip select and output enable together. It captures the memory data into the read-data output on the clock edge where the read interval expires, raises both strobes, and pulses completion.
- R6: Completion is high for exactly one clock per accepted request. A request presented while the block is not ready is ignored and leaves memory contents untouched.
- R7: From accept to completion, a write takes WE_CYC + max(hold, cycle - WE_CYC) clocks and a read takes max(address access, output-enable access, cycle) clocks. Each interval is ceil(ns / clock period) with a minimum of 1.
- R8: The read-data output keeps its last captured value across write cycles.
- R9: The data bus is never driven while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| req_ready | output | 1 | Block idle; a request is taken on this clock |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DATA_W | Byte captured by the last read |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | DATA_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Tristate enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data returned from memory |

## Verification
The bench runs at a 20 ns clock with the default access and strobe figures, and raises the cycle time to 100 ns. With these values the write strobe window is 3 clocks, set by strobe width rather than data setup. The write hold is stretched from 1 to 2 clocks by the cycle-time remainder, and the read interval of 5 clocks is set by cycle time rather than access time. That choice brings the stretching arithmetic and the three-way read maximum into reach. The memory model returns a poison byte until the address-access time has elapsed, so an early capture shows up as wrong data.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WR_STROBE = 2'd1,
    ST_WR_HOLD   = 2'd2,
    ST_RD_ACCESS = 2'd3
  } seq_state_t;

  // Round a nanosecond figure up to whole clocks, never below one clock.
  function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Remainder of a minimum cycle after a first phase, zero if already covered.
  function automatic int unsigned remain(input int unsigned total, input int unsigned used);
    return (total > used) ? (total - used) : 0;
  endfunction

endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_cyc_pkg::*;
#(
  parameter int unsigned WE_CYC   = 3,
  parameter int unsigned HOLD_CYC = 1,
  parameter int unsigned RD_CYC   = 4,
  parameter int unsigned CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             done
);

  localparam logic [CNT_W-1:0] WE_LOAD   = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);

  seq_state_t state_q;
  logic       strobe_end;

  assign ready      = (state_q == ST_IDLE);
  assign accept     = ready && req_valid;
  assign strobe_end = (state_q == ST_WR_STROBE) && tmr_expired;
  assign capture    = (state_q == ST_RD_ACCESS) && tmr_expired;
  assign tmr_load   = accept || strobe_end;

  always_comb begin
    if (accept) tmr_val = req_write ? WE_LOAD : RD_LOAD;
    else        tmr_val = HOLD_LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ce_n <= 1'b0;
            if (req_write) begin
              we_n    <= 1'b0;
              dq_oe   <= 1'b1;
              state_q <= ST_WR_STROBE;
            end else begin
              oe_n    <= 1'b0;
              state_q <= ST_RD_ACCESS;
            end
          end
        end
        ST_WR_STROBE: begin
          if (tmr_expired) begin
            we_n    <= 1'b1;
            state_q <= ST_WR_HOLD;
          end
        end
        ST_WR_HOLD: begin
          if (tmr_expired) begin
            ce_n    <= 1'b1;
            dq_oe   <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_RD_ACCESS: begin
          if (tmr_expired) begin
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_bus_regs.sv
module sram_bus_regs #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (capture) rd_data <= mem_dq_in;
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_cyc_pkg::*;
#(
  parameter int unsigned ADDR_W           = 19,
  parameter int unsigned DATA_W           = 8,
  parameter int unsigned CLK_NS           = 20,
  parameter int unsigned T_WE_PULSE_NS    = 55,
  parameter int unsigned T_WDATA_SETUP_NS = 30,
  parameter int unsigned T_ADDR_HOLD_NS   = 5,
  parameter int unsigned T_ADDR_ACCESS_NS = 70,
  parameter int unsigned T_OE_ACCESS_NS   = 35,
  parameter int unsigned T_CYCLE_NS       = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned CYC_CYC  = ns_to_clk(T_CYCLE_NS, CLK_NS);
  localparam int unsigned WE_CYC   = umax(ns_to_clk(T_WE_PULSE_NS, CLK_NS),
                                          ns_to_clk(T_WDATA_SETUP_NS, CLK_NS));
  localparam int unsigned HOLD_CYC = umax(ns_to_clk(T_ADDR_HOLD_NS, CLK_NS),
                                          remain(CYC_CYC, WE_CYC));
  localparam int unsigned RD_CYC   = umax(umax(ns_to_clk(T_ADDR_ACCESS_NS, CLK_NS),
                                               ns_to_clk(T_OE_ACCESS_NS, CLK_NS)), CYC_CYC);
  localparam int unsigned MAX_CYC  = umax(umax(WE_CYC, HOLD_CYC), RD_CYC);
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  // Named internal events, also observed by the bound checker.
  logic             req_accept;
  logic             rd_capture;
  logic             tmr_load;
  logic             tmr_expired;
  logic [CNT_W-1:0] tmr_val;

  sram_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_seq_fsm #(
    .WE_CYC   (WE_CYC),
    .HOLD_CYC (HOLD_CYC),
    .RD_CYC   (RD_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .accept      (req_accept),
    .capture     (rd_capture),
    .ready       (req_ready),
    .ce_n        (mem_ce_n),
    .oe_n        (mem_oe_n),
    .we_n        (mem_we_n),
    .dq_oe       (mem_dq_oe),
    .done        (done)
  );

  sram_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (req_accept),
    .capture    (rd_capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/sram_cyc_chk.sv
module sram_cyc_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WE_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic              rd_capture
);

  logic [15:0] we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_low_cnt <= '0;
    else if (!mem_we_n) we_low_cnt <= we_low_cnt + 16'd1;
    else                we_low_cnt <= '0;
  end

  assert_oe_high_in_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  assert_we_pulse_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == 16'(WE_CYC)));

  assert_bus_under_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_ce_n));

  assert_wdata_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  assert_capture_ends_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> (done && mem_ce_n && mem_oe_n));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

endmodule

bind sram_cycle_ctrl sram_cyc_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WE_CYC (WE_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_oe  (mem_dq_oe),
  .mem_dq_out (mem_dq_out),
  .mem_addr   (mem_addr),
  .done       (done),
  .rd_capture (rd_capture)
);

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb;

  localparam int AW     = 19;
  localparam int DW     = 8;
  localparam int CLK_NS = 20;
  localparam int CYC_NS = 100;

  // Independent restatement of the interval arithmetic.
  function automatic int clks(input int ns);
    int q;
    q = ns / CLK_NS;
    if (ns % CLK_NS != 0) q = q + 1;
    return (q == 0) ? 1 : q;
  endfunction
  function automatic int bigger(input int a, input int b);
    if (a >= b) return a;
    return b;
  endfunction

  localparam int WE_EXP   = bigger(clks(55), clks(30));
  localparam int WR_TOTAL = WE_EXP + bigger(clks(5), clks(CYC_NS) - WE_EXP);
  localparam int RD_TOTAL = bigger(bigger(clks(70), clks(35)), clks(CYC_NS));
  localparam int ACC_EXP  = clks(70);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, done, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_out;
  logic [DW-1:0] mem_dq_in;
  logic [AW-1:0] mem_addr;

  always #(CLK_NS/2) clk = ~clk;

  sram_cycle_ctrl #(.CLK_NS(CLK_NS), .T_CYCLE_NS(CYC_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Memory model: 256 bytes indexed by the low address byte, poison until access time.
  logic [DW-1:0] model_mem [256];
  int            acc_cnt;

  initial for (int i = 0; i < 256; i++) model_mem[i] = 8'h00;

  always @(posedge mem_we_n)
    if (!mem_ce_n && mem_dq_oe) model_mem[mem_addr[7:0]] = mem_dq_out;

  always @(posedge clk)
    if (!rst_n || mem_ce_n || mem_oe_n) acc_cnt <= 0;
    else                                acc_cnt <= acc_cnt + 1;

  always_comb begin
    if (acc_cnt >= ACC_EXP - 1) mem_dq_in = model_mem[mem_addr[7:0]];
    else                        mem_dq_in = 8'hEE;
  end

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int issued = 0;
  int dones  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    bit            wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int            start;
  } item_t;

  item_t         sb_q[$];
  logic [DW-1:0] shadow [256];
  logic [DW-1:0] last_rd = '0;
  int we_cnt = 0, oe_err = 0, data_err = 0, addr_err = 0, contention = 0;

  initial for (int i = 0; i < 256; i++) shadow[i] = 8'h00;

  always @(posedge clk) cyc <= cyc + 1;

  // Driver: push the expectation, then present the request for one clock.
  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (wr) shadow[a[7:0]] = d;
    it.wr = wr; it.addr = a; it.data = wr ? d : shadow[a[7:0]]; it.start = cyc;
    sb_q.push_back(it);
    issued++;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: observe the memory side and score each completion.
  always @(negedge clk) if (rst_n) begin
    if (mem_dq_oe && !mem_oe_n) contention++;
    if (!mem_ce_n && sb_q.size() > 0) begin
      if (mem_addr != sb_q[0].addr) addr_err++;
      if (!mem_we_n) we_cnt++;
      if (!mem_oe_n && sb_q[0].wr) oe_err++;
      if (mem_dq_oe && mem_dq_out != sb_q[0].data) data_err++;
    end
    if (done) begin
      item_t it;
      dones++;
      if (sb_q.size() == 0) begin
        chk(1'b0, "R6 completion with nothing outstanding", 1, 0);
      end else begin
        it = sb_q.pop_front();
        chk(cyc - it.start == (it.wr ? WR_TOTAL : RD_TOTAL) + 1, "R7 accept-to-done clocks",
            cyc - it.start - 1, it.wr ? WR_TOTAL : RD_TOTAL);
        chk(addr_err == 0, "R4 address held", addr_err, 0);
        if (it.wr) begin
          chk(we_cnt == WE_EXP, "R2 write strobe clocks", we_cnt, WE_EXP);
          chk(oe_err == 0, "R2 output enable high in write", oe_err, 0);
          chk(data_err == 0, "R3 write data on bus", data_err, 0);
          chk(rd_data == last_rd, "R8 read data kept over write", rd_data, last_rd);
        end else begin
          chk(we_cnt == 0, "R5 no write strobe in read", we_cnt, 0);
          chk(rd_data == it.data, "R5 captured read data", rd_data, it.data);
          last_rd = rd_data;
        end
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R3 strobes and bus released",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
      end
      we_cnt = 0; oe_err = 0; data_err = 0; addr_err = 0;
    end
  end

  bit finished = 0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1 strobes idle in reset",
        {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    chk(!mem_dq_oe && !done && req_ready, "R1 bus, done, ready in reset",
        {mem_dq_oe, done, req_ready}, 3'b001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && mem_ce_n, "R1 quiet after reset release", {done, mem_ce_n}, 2'b01);

    issue(1'b0, 19'h00010, 8'h00);          // read of unwritten byte
    issue(1'b1, 19'h7FF21, 8'hA5);
    issue(1'b1, 19'h40042, 8'h3C);
    issue(1'b0, 19'h7FF21, 8'h00);
    issue(1'b1, 19'h00063, 8'hFF);          // write right after read: R8
    issue(1'b0, 19'h40042, 8'h00);
    issue(1'b0, 19'h00063, 8'h00);
    issue(1'b1, 19'h12384, 8'h01);

    // R6: a request while busy is ignored; 0x99 must stay at its old value.
    issue(1'b1, 19'h00011, 8'h5A);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00099; req_wdata = 8'h77;
    @(negedge clk);
    chk(!req_ready, "R6 block busy while stray request held", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    issue(1'b0, 19'h00099, 8'h00);
    issue(1'b0, 19'h00011, 8'h00);
    issue(1'b0, 19'h12384, 8'h00);

    while (sb_q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(dones == issued, "R6 one completion per accepted request", dones, issued);
    chk(contention == 0, "R9 no bus drive with output enable low", contention, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule